// File: doc/BRIEF.md
# HDLC Receive Deframer

This block takes a serial HDLC line, one bit per cycle in which `bit_en_i` is high, and turns it into a stream of tagged bytes for a downstream receive queue. It watches for three line patterns: the frame delimiter `0111_1110`, the go-ahead pattern `0_1111111_0`, and an idle line of fifteen or more ones. It removes the zero that a transmitter inserts after five ones. The frame check sequence is verified by the residue method: the CRC is accumulated over data and FCS together, and the register must read 0xF0B8 when the closing delimiter arrives.

Each write carries 8 data bits and a 2-bit tag. The last three complete bytes of a frame are held back. The two FCS bytes are therefore never written, and the final data byte can carry the frame's end status. Frames that are too short are dropped, or reduced to a single entry marked bad. A run of seven ones inside a frame ends it and sends the receiver back to hunting for a delimiter.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, `wr_o`, `flag_o`, `go_ahead_o`, `abort_o` and `idle_o` are all low. All outputs are registered and change on the clock edge that samples the bit responsible.
- R2: `bit_i` is ignored in every cycle where `bit_en_i` is low, including toggles that spell a delimiter.
- R3: A zero received after exactly five ones is discarded. Bytes are assembled LSB first. A byte is written only once three more complete bytes of the same frame follow it. The first entry of a frame carries tag 2'b01 and later entries carry tag 2'b00.
- R4: `0111_1110` pulses `flag_o`, closes any open frame and opens a new one. The CRC starts at 0xFFFF and is shifted LSB first with polynomial 0x8408. At a closing delimiter, the oldest held byte is written with tag 2'b10 when the frame has a whole number of bytes and the CRC equals 0xF0B8. The two FCS bytes are never written.
- R5: At a closing delimiter with a CRC other than 0xF0B8, the oldest held byte is written with tag 2'b11.
- R6: A frame with fewer than 25 bits after zero removal writes nothing.
- R7: A frame with 25 to 31 bits after zero removal writes exactly one entry: its first byte, with tag 2'b11.
- R8: A frame of 32 or more bits whose length is not a multiple of 8 ends with the oldest held complete byte tagged 2'b11. The partial byte is dropped.
- R9: A seventh consecutive one in an open frame that has carried at least one data byte pulses `abort_o`. If entries of that frame were already written, the oldest held byte is written with tag 2'b11. The receiver then writes nothing until the next delimiter. Seven ones directly after a delimiter do not pulse `abort_o`.
- R10: The pattern `0_1111111_0` pulses `go_ahead_o`.
- R11: `idle_o` is high after fifteen consecutive ones and low once a zero arrives. It stays low after fourteen ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Line bit valid this cycle |
| bit_i | input | 1 | Line bit |
| wr_o | output | 1 | Queue write strobe |
| wr_data_o | output | 8 | Byte written |
| wr_tag_o | output | 2 | 00 middle, 01 first, 10 good end, 11 bad end or abort |
| flag_o | output | 1 | Delimiter seen |
| go_ahead_o | output | 1 | Go-ahead seen |
| abort_o | output | 1 | Open frame aborted |
| idle_o | output | 1 | Line idle |

## Verification
The hardest case is an abort that arrives after some entries of the frame have already been released. It takes at least four complete bytes, followed by a run of ones that never passes through the stuffing logic. The bench sends five bytes whose last byte ends in zeros, then drives sixteen raw ones. That single run also reaches the idle threshold. The two length windows below 32 bits are reached by sending stuffed bit strings with no FCS, so the bit count after zero removal is exact.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  typedef enum logic [1:0] {
    TAG_MID     = 2'b00,
    TAG_FIRST   = 2'b01,
    TAG_END_OK  = 2'b10,
    TAG_END_BAD = 2'b11
  } rx_tag_e;

  localparam int STUFF_ONES = 5;
  localparam int FLAG_ONES  = 6;
  localparam int GA_ONES    = 7;
  localparam int BYTE_W     = 8;
endpackage

// File: rtl/hdlc_rx_pattern.sv
module hdlc_rx_pattern
  import hdlc_rx_pkg::*;
#(
  parameter int IDLE_ONES = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic push_o,
  output logic flag_ev_o,
  output logic abort_ev_o,
  output logic flag_o,
  output logic go_ahead_o,
  output logic idle_o
);
  localparam int CW = $clog2(IDLE_ONES + 1);

  logic [CW-1:0] ones_q;
  logic          sat;
  logic          ga_ev;

  assign sat        = (ones_q == CW'(IDLE_ONES));
  assign idle_o     = sat;
  assign flag_ev_o  = bit_en_i && !bit_i && (ones_q == CW'(FLAG_ONES));
  assign abort_ev_o = bit_en_i &&  bit_i && (ones_q == CW'(FLAG_ONES));
  assign ga_ev      = bit_en_i && !bit_i && (ones_q == CW'(GA_ONES));
  // ones up to six may still be data; a zero after five is stuffing
  assign push_o     = bit_en_i && (bit_i ? (ones_q < CW'(FLAG_ONES))
                                         : (ones_q < CW'(STUFF_ONES)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q     <= '0;
      flag_o     <= 1'b0;
      go_ahead_o <= 1'b0;
    end else begin
      flag_o     <= flag_ev_o;
      go_ahead_o <= ga_ev;
      if (bit_en_i) ones_q <= bit_i ? (sat ? ones_q : ones_q + 1'b1) : '0;
    end
  end

  AST_IDLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> $past(bit_en_i && bit_i));  // R11
  AST_FLAG_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> $past(bit_en_i && !bit_i));  // R4
  AST_GA_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_ahead_o |-> !idle_o);  // R10
  AST_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(idle_o));  // R2
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h8408,
  parameter logic [W-1:0] SEED = 16'hFFFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb    = crc_q[0] ^ bit_i;
  assign crc_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= SEED;
    else if (init_i) crc_q <= SEED;
    else if (en_i)   crc_q <= (crc_q >> 1) ^ (fb ? POLY : '0);
  end

  AST_CRC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !en_i) |=> $stable(crc_q));  // R4
endmodule

// File: rtl/hdlc_rx_assembler.sv
module hdlc_rx_assembler
  import hdlc_rx_pkg::*;
#(
  parameter int          HOLD     = 3,
  parameter int          MIN_BITS = 25,
  parameter logic [15:0] RESIDUE  = 16'hF0B8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              push_bit_i,
  input  logic              flag_i,
  input  logic              abort_i,
  input  logic [15:0]       crc_i,
  output logic              crc_init_o,
  output logic              commit_o,
  output logic              commit_bit_o,
  output logic              wr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [1:0]        wr_tag_o,
  output logic              abort_o
);
  localparam int PEND      = FLAG_ONES + 1;
  localparam int PCW       = $clog2(PEND + 1);
  localparam int FULL_BITS = BYTE_W * (HOLD + 1);
  localparam int BW        = $clog2(FULL_BITS + 1);
  localparam int HCW       = $clog2(HOLD + 1);

  logic [PEND-1:0]   pend_q;
  logic [PCW-1:0]    pend_cnt_q;
  logic              synced_q, first_q;
  logic [BW-1:0]     nbits_q;
  logic [2:0]        bidx_q;
  logic [BYTE_W-1:0] sr_q, new_byte;
  logic [BYTE_W-1:0] hold_q [HOLD];
  logic [HCW-1:0]    hcnt_q;
  rx_tag_e           end_tag;

  assign crc_init_o   = flag_i;
  assign commit_o     = synced_q && push_i && (pend_cnt_q == PCW'(PEND));
  assign commit_bit_o = pend_q[PEND-1];
  assign new_byte     = {commit_bit_o, sr_q[BYTE_W-1:1]};
  assign end_tag      = (nbits_q < BW'(FULL_BITS) || bidx_q != 3'd0 || crc_i != RESIDUE)
                        ? TAG_END_BAD : TAG_END_OK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      pend_cnt_q <= '0;
      synced_q   <= 1'b0;
      first_q    <= 1'b0;
      nbits_q    <= '0;
      bidx_q     <= '0;
      sr_q       <= '0;
      hcnt_q     <= '0;
      for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
      wr_o       <= 1'b0;
      wr_data_o  <= '0;
      wr_tag_o   <= TAG_MID;
      abort_o    <= 1'b0;
    end else begin
      wr_o    <= 1'b0;
      abort_o <= 1'b0;
      if (flag_i) begin
        if (synced_q && nbits_q >= BW'(MIN_BITS)) begin
          wr_o      <= 1'b1;
          wr_data_o <= hold_q[HOLD-1];
          wr_tag_o  <= end_tag;
        end
        synced_q   <= 1'b1;
        first_q    <= 1'b0;
        nbits_q    <= '0;
        bidx_q     <= '0;
        hcnt_q     <= '0;
        pend_cnt_q <= '0;
      end else if (abort_i && synced_q) begin
        synced_q <= 1'b0;
        if (nbits_q != '0) abort_o <= 1'b1;
        if (first_q) begin
          wr_o      <= 1'b1;
          wr_data_o <= hold_q[HOLD-1];
          wr_tag_o  <= TAG_END_BAD;
        end
      end else if (push_i && synced_q) begin
        pend_q <= {pend_q[PEND-2:0], push_bit_i};
        if (pend_cnt_q != PCW'(PEND)) pend_cnt_q <= pend_cnt_q + 1'b1;
        if (commit_o) begin
          if (nbits_q != BW'(FULL_BITS)) nbits_q <= nbits_q + 1'b1;
          bidx_q <= bidx_q + 1'b1;
          sr_q   <= new_byte;
          if (bidx_q == 3'd7) begin
            hold_q[0] <= new_byte;
            for (int i = 1; i < HOLD; i++) hold_q[i] <= hold_q[i-1];
            if (hcnt_q == HCW'(HOLD)) begin
              wr_o      <= 1'b1;
              wr_data_o <= hold_q[HOLD-1];
              wr_tag_o  <= first_q ? TAG_MID : TAG_FIRST;
              first_q   <= 1'b1;
            end else begin
              hcnt_q <= hcnt_q + 1'b1;
            end
          end
        end
      end
    end
  end

  AST_END_AT_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && wr_tag_o[1]) |-> $past(flag_i || abort_i));  // R5
  AST_GOOD_RESIDUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && wr_tag_o == TAG_END_OK) |-> $past(crc_i) == RESIDUE);  // R4
  AST_ABORT_HUNTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !synced_q);  // R9
  AST_BODY_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !wr_tag_o[1]) |-> $past(commit_o));  // R3
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int          IDLE_ONES = 15,
  parameter int          HOLD      = 3,
  parameter int          MIN_BITS  = 25,
  parameter logic [15:0] RESIDUE   = 16'hF0B8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       bit_i,
  output logic       wr_o,
  output logic [7:0] wr_data_o,
  output logic [1:0] wr_tag_o,
  output logic       flag_o,
  output logic       go_ahead_o,
  output logic       abort_o,
  output logic       idle_o
);
  logic        push, flag_ev, abort_ev;
  logic        crc_init, commit, commit_bit;
  logic [15:0] crc;

  hdlc_rx_pattern #(.IDLE_ONES(IDLE_ONES)) u_pat (
    .clk_i, .rst_ni, .bit_en_i, .bit_i,
    .push_o(push), .flag_ev_o(flag_ev), .abort_ev_o(abort_ev),
    .flag_o, .go_ahead_o, .idle_o
  );

  hdlc_rx_crc u_crc (
    .clk_i, .rst_ni, .init_i(crc_init), .en_i(commit), .bit_i(commit_bit), .crc_o(crc)
  );

  hdlc_rx_assembler #(.HOLD(HOLD), .MIN_BITS(MIN_BITS), .RESIDUE(RESIDUE)) u_asm (
    .clk_i, .rst_ni, .push_i(push), .push_bit_i(bit_i), .flag_i(flag_ev),
    .abort_i(abort_ev), .crc_i(crc), .crc_init_o(crc_init), .commit_o(commit),
    .commit_bit_o(commit_bit), .wr_o, .wr_data_o, .wr_tag_o, .abort_o
  );

  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flag_o, go_ahead_o, abort_o}));  // R9
endmodule

// File: tb/hdlc_rx_deframer_test.sv
module hdlc_rx_deframer_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic       wr_o, flag_o, go_ahead_o, abort_o, idle_o;
  logic [7:0] wr_data_o;
  logic [1:0] wr_tag_o;

  always #5 clk = ~clk;

  hdlc_rx_deframer uut (
    .clk_i(clk), .rst_ni, .bit_en_i(bit_en), .bit_i(bit_in),
    .wr_o, .wr_data_o, .wr_tag_o, .flag_o, .go_ahead_o, .abort_o, .idle_o
  );

  int total = 0, bad = 0, ones_run = 0;
  int cap_n = 0, n_flag = 0, n_ga = 0, n_abort = 0;
  logic [7:0] cap_d [64];
  logic [1:0] cap_t [64];
  logic [7:0] fb [16];

  // {corrupt, data length, seed}
  localparam logic [16:0] CASES [6] = '{
    {1'b0, 8'd4, 8'hFF}, {1'b0, 8'd2, 8'h7E}, {1'b1, 8'd5, 8'h12},
    {1'b0, 8'd1, 8'h55}, {1'b0, 8'd9, 8'hF0}, {1'b1, 8'd3, 8'hFF}
  };

  always @(negedge clk) if (rst_ni) begin
    if (wr_o && cap_n < 64) begin
      cap_d[cap_n] = wr_data_o;
      cap_t[cap_n] = wr_tag_o;
      cap_n++;
    end
    if (flag_o) n_flag++;
    if (go_ahead_o) n_ga++;
    if (abort_o) n_abort++;
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic raw(logic b);
    @(negedge clk); bit_en = 1'b1; bit_in = b;
    @(negedge clk); bit_en = 1'b0; bit_in = ~b;
  endtask

  task automatic dbit(logic b);
    raw(b);
    if (b) begin
      ones_run++;
      if (ones_run == 5) begin raw(1'b0); ones_run = 0; end
    end else ones_run = 0;
  endtask

  task automatic dbyte(logic [7:0] v);
    for (int i = 0; i < 8; i++) dbit(v[i]);
  endtask

  task automatic flag();
    raw(1'b0);
    repeat (6) raw(1'b1);
    raw(1'b0);
    ones_run = 0;
  endtask

  function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      logic f;
      f = c[0] ^ v[i];
      c = c >> 1;
      if (f) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic run_frame(int len, logic [7:0] seed, logic corrupt, logic noise);
    logic [15:0] c;
    logic [15:0] fcs;
    c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      fb[i] = seed ^ 8'(i * 59);
      c = crc_byte(c, fb[i]);
    end
    fcs = ~c;
    if (corrupt) fcs[0] = ~fcs[0];
    flag();
    cap_n = 0;
    for (int i = 0; i < len; i++) begin
      dbyte(fb[i]);
      if (noise && i == 0)
        for (int k = 0; k < 24; k++) begin
          @(negedge clk); bit_in = 1'(8'h7E >> (k % 8));  // R2 delimiter shape, gated off
        end
    end
    dbyte(fcs[7:0]);
    dbyte(fcs[15:8]);
    flag();
    repeat (3) @(negedge clk);
    if (len < 2) chk("R6 short frame entries", 32'(cap_n), 0);
    else begin
      chk(noise ? "R2 entry count" : "R3 entry count", 32'(cap_n), 32'(len));
      for (int i = 0; i < len && i < cap_n; i++) begin
        chk("R3 data", {24'd0, cap_d[i]}, {24'd0, fb[i]});
        if (i == len - 1)
          chk(corrupt ? "R5 end tag" : "R4 end tag", {30'd0, cap_t[i]},
              corrupt ? 32'd3 : 32'd2);
        else
          chk("R3 body tag", {30'd0, cap_t[i]}, (i == 0) ? 32'd1 : 32'd0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int nab;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {27'd0, wr_o, flag_o, go_ahead_o, abort_o, idle_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    flag();
    @(negedge clk);
    chk("R4 flag pulse", 32'(n_flag), 1);

    for (int c = 0; c < 6; c++)
      run_frame(int'(CASES[c][15:8]), CASES[c][7:0], CASES[c][16], 1'b0);
    run_frame(4, 8'hC5, 1'b0, 1'b1);

    // R7: 27 bits
    cap_n = 0;
    dbyte(8'h5A); dbyte(8'hC3); dbyte(8'h3C); dbit(0); dbit(1); dbit(1);
    flag(); repeat (3) @(negedge clk);
    chk("R7 entry count", 32'(cap_n), 1);
    chk("R7 data", {24'd0, cap_d[0]}, 32'h5A);
    chk("R7 tag", {30'd0, cap_t[0]}, 3);

    // R6: 20 bits
    cap_n = 0;
    dbyte(8'hFF); dbyte(8'h81); dbit(1); dbit(1); dbit(0); dbit(1);
    flag(); repeat (3) @(negedge clk);
    chk("R6 20-bit frame", 32'(cap_n), 0);

    // R8: 35 bits
    cap_n = 0;
    dbyte(8'hA1); dbyte(8'hB2); dbyte(8'hC3); dbyte(8'hD4); dbit(1); dbit(0); dbit(1);
    flag(); repeat (3) @(negedge clk);
    chk("R8 entry count", 32'(cap_n), 2);
    chk("R8 first data", {24'd0, cap_d[0]}, 32'hA1);
    chk("R8 first tag", {30'd0, cap_t[0]}, 1);
    chk("R8 end data", {24'd0, cap_d[1]}, 32'hB2);
    chk("R8 end tag", {30'd0, cap_t[1]}, 3);

    // R10 and R11: go-ahead right after a delimiter, then idle threshold
    nab = n_abort;
    repeat (7) raw(1'b1);
    raw(1'b0);
    @(negedge clk);
    chk("R10 go-ahead pulse", 32'(n_ga), 1);
    chk("R9 no abort after bare flag", 32'(n_abort), 32'(nab));
    repeat (14) raw(1'b1);
    chk("R11 idle after 14 ones", {31'd0, idle_o}, 0);
    raw(1'b1);
    chk("R11 idle after 15 ones", {31'd0, idle_o}, 1);
    raw(1'b0);
    chk("R11 idle cleared", {31'd0, idle_o}, 0);

    // R9: abort after entries were released
    flag();
    cap_n = 0;
    nab = n_abort;
    dbyte(8'h11); dbyte(8'h22); dbyte(8'h33); dbyte(8'h44); dbyte(8'h00);
    repeat (16) raw(1'b1);
    @(negedge clk);
    chk("R9 abort pulse", 32'(n_abort), 32'(nab + 1));
    chk("R9 entry count", 32'(cap_n), 2);
    chk("R9 first tag", {30'd0, cap_t[0]}, 1);
    chk("R9 aborted data", {24'd0, cap_d[1]}, 32'h22);
    chk("R9 aborted tag", {30'd0, cap_t[1]}, 3);
    chk("R11 idle after abort run", {31'd0, idle_o}, 1);
    raw(1'b0);
    ones_run = 0;
    dbyte(8'h5A); dbyte(8'h6B); dbyte(8'h7C); dbyte(8'h8D); dbyte(8'h9E);
    flag(); repeat (3) @(negedge clk);
    chk("R9 hunting writes nothing", 32'(cap_n), 2);

    finish_run();
  end
endmodule